// File: doc/BRIEF.md
# Cycle-Stealing Byte Copy Engine

This block moves bytes on a shared processor bus without running processor code. Software loads a source address, a destination address and a byte count through a small register window. It then writes a control byte that sets the transfer kind and starts the engine. While the engine owns the bus it drives the address, the read/write line and the write data, so memory and I/O see the same kind of bus cycle the processor would produce. Each byte takes two owned cycles: a read into an internal holding register, then a write of that byte.

The engine can take the bus in two ways. In steal mode it uses only cycles in which the processor reports, on its two status outputs, that no valid address is on the bus. It enables its drivers combinationally within that same cycle. In burst mode it raises a bus request and keeps the bus for as long as the grant input stays high. Besides memory-to-memory copies, it can stream a memory block into a single port address or collect bytes from a port into a memory block. Port-side cycles can optionally be paced by a device request line, and each one is marked with an acknowledge output. To fill a range with one byte, store the byte at the start of the range and run a port-to-memory copy whose fixed source is that first location and whose destination begins one byte later. When the engine finishes, or when software aborts it, a done flag is set, and an interrupt follows if it is enabled.

Top module: `steal_copy_dma`

## Requirements
- R1: Register window (index on `regSel`, one byte each): 0..2 source address with the low byte first, 3..5 destination address, 6..7 count with the low byte first, 8 control, 9 status. Control bits: bit0 start, bits 2:1 kind, bit3 burst, bit4 interrupt enable, bit5 pacing. Reading control returns the stored bits with busy in bit0. Status returns busy in bit0 and done in bit1. After reset every register reads 0, and `busOe`, `busDataOe`, `busReq`, `dack` and `irq` are low.
- R2: When burst is clear, the engine owns the bus (`busOe` high) only in cycles where `vda` and `vpa` are both low, and the owned cycle is the same cycle in which they are low.
- R3: Kind 0 (and 3) copies count bytes from source+i to destination+i. Afterwards both address registers have advanced by the count, the count register reads 0, and no byte past the range is written.
- R4: Kind 1 reads successive source bytes and writes every one to the fixed destination address, which stays unchanged.
- R5: Kind 2 reads every byte from the fixed source address and writes successive destination bytes. Seeding a byte at A and running kind 2 from A to A+1 fills the range with that byte.
- R6: A byte is one read cycle (`busRwb`=1, source address) latched at the clock edge, followed by one write cycle (`busRwb`=0, destination address, `busDataOe`=1). With a continuous grant and no pacing, N bytes take exactly 2N consecutive owned cycles.
- R7: In burst mode `busReq` is high while busy, and `busOe` stays low in every cycle without `busGrant`.
- R8: When pacing is set, a port-side cycle (the read in kind 2, the write in kind 1) happens only while `dreq` is high. `dack` is high exactly in the owned cycles that access the port side.
- R9: Done is set by the final write. `irq` equals done ANDed with the interrupt enable. Reading status clears done and so drops `irq`.
- R10: A count of 0 means 65536 bytes.
- R11: While busy, writes to the address and count registers are ignored, and so is a control write with bit0 set.
- R12: A control write with bit0 clear while busy stops the transfer at once. No further bus cycle follows, and done is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, one bus cycle per period |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Register window select, active low |
| regSel | input | 4 | Register index |
| cpuRwb | input | 1 | Processor direction for register access, 1 = read |
| cpuDataIn | input | 8 | Register write data |
| regDataOut | output | 8 | Register read data |
| vda | input | 1 | Processor valid-data-address status |
| vpa | input | 1 | Processor valid-program-address status |
| busReq | output | 1 | Burst-mode bus request |
| busGrant | input | 1 | Burst-mode bus grant |
| busAddr | output | 24 | Address driven while owning the bus |
| busOe | output | 1 | Output enable for address and read/write line |
| busRwb | output | 1 | Bus direction driven by the engine, 1 = read |
| busDataOut | output | 8 | Write data |
| busDataOe | output | 1 | Output enable for write data |
| busDataIn | input | 8 | Read data returned in an owned read cycle |
| dreq | input | 1 | Device service request for the port side |
| dack | output | 1 | Port-side access acknowledge |
| irq | output | 1 | Completion interrupt |

## Verification
The properties assume that the processor status lines, `busGrant` and `dreq` are stable for a whole clock period and change only between edges. They also assume that `busGrant` is never high unless `busReq` is, and that register accesses last one cycle each. The bench drives all of these from the falling edge and builds the grant from the request and a delay counter, so the grant never runs ahead of the request. Status reads that fall in the same cycle as a final write are left out of the interrupt-clear property.

// File: rtl/steal_copy_pkg.sv
`timescale 1ns/1ps
package steal_copy_pkg;

  typedef enum logic [1:0] {
    KIND_MEM2MEM  = 2'd0,
    KIND_MEM2PORT = 2'd1,
    KIND_PORT2MEM = 2'd2,
    KIND_MEM2MEM2 = 2'd3
  } xferKind_e;

  // Control byte bits 5:1, MSB first
  typedef struct packed {
    logic      pace;
    logic      irqEn;
    logic      burst;
    xferKind_e kind;
  } xferCfg_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic rdPhase;
    logic rdCycle;
    logic wrCycle;
  } seqStrobe_t;

endpackage

// File: rtl/steal_copy_dp.sv
`timescale 1ns/1ps
module steal_copy_dp
  import steal_copy_pkg::*;
#(
  parameter int SEL_W  = 4,
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              cpuRwb,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [DATA_W-1:0] cpuDataIn,
  output logic [DATA_W-1:0] regDataOut,
  input  logic              busyIn,
  input  logic              doneIn,
  input  seqStrobe_t        strobe,
  input  logic [DATA_W-1:0] busDataIn,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDataOut,
  output xferCfg_t          cfg,
  output logic              lastByte,
  output logic              ctlWrite,
  output logic              statRead
);

  localparam int ADDR_BYTES = (ADDR_W + DATA_W - 1) / DATA_W;
  localparam int CNT_BYTES  = (CNT_W + DATA_W - 1) / DATA_W;
  localparam int ADDR_PAD   = ADDR_BYTES * DATA_W;
  localparam int CNT_PAD    = CNT_BYTES * DATA_W;
  localparam int SRC_BASE   = 0;
  localparam int DST_BASE   = ADDR_BYTES;
  localparam int CNT_BASE   = 2 * ADDR_BYTES;
  localparam int CTL_IDX    = CNT_BASE + CNT_BYTES;
  localparam int STAT_IDX   = CTL_IDX + 1;

  logic [ADDR_PAD-1:0] srcReg, dstReg;
  logic [CNT_PAD-1:0]  cntReg;
  logic [DATA_W-1:0]   byteLatch;
  logic                regWr, regRd, srcStep, dstStep;

  assign regWr    = !csN && !cpuRwb;
  assign regRd    = !csN && cpuRwb;
  assign ctlWrite = regWr && (regSel == SEL_W'(CTL_IDX));
  assign statRead = regRd && (regSel == SEL_W'(STAT_IDX));
  assign srcStep  = (cfg.kind != KIND_PORT2MEM);
  assign dstStep  = (cfg.kind != KIND_MEM2PORT);
  assign lastByte = (cntReg[CNT_W-1:0] == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcReg    <= '0;
      dstReg    <= '0;
      cntReg    <= '0;
      byteLatch <= '0;
      cfg       <= '0;
    end else begin
      if (regWr && !busyIn) begin
        for (int b = 0; b < ADDR_BYTES; b++) begin
          if (regSel == SEL_W'(SRC_BASE + b)) srcReg[b*DATA_W +: DATA_W] <= cpuDataIn;
          if (regSel == SEL_W'(DST_BASE + b)) dstReg[b*DATA_W +: DATA_W] <= cpuDataIn;
        end
        for (int b = 0; b < CNT_BYTES; b++) begin
          if (regSel == SEL_W'(CNT_BASE + b)) cntReg[b*DATA_W +: DATA_W] <= cpuDataIn;
        end
        if (regSel == SEL_W'(CTL_IDX)) cfg <= xferCfg_t'(cpuDataIn[5:1]);
      end
      if (strobe.rdCycle) begin
        byteLatch <= busDataIn;
        if (srcStep) srcReg <= ADDR_PAD'(srcReg[ADDR_W-1:0] + ADDR_W'(1));
      end
      if (strobe.wrCycle) begin
        if (dstStep) dstReg <= ADDR_PAD'(dstReg[ADDR_W-1:0] + ADDR_W'(1));
        cntReg <= CNT_PAD'(cntReg[CNT_W-1:0] - CNT_W'(1));
      end
    end
  end

  always_comb begin
    regDataOut = '0;
    for (int b = 0; b < ADDR_BYTES; b++) begin
      if (regSel == SEL_W'(SRC_BASE + b)) regDataOut = srcReg[b*DATA_W +: DATA_W];
      if (regSel == SEL_W'(DST_BASE + b)) regDataOut = dstReg[b*DATA_W +: DATA_W];
    end
    for (int b = 0; b < CNT_BYTES; b++) begin
      if (regSel == SEL_W'(CNT_BASE + b)) regDataOut = cntReg[b*DATA_W +: DATA_W];
    end
    if (regSel == SEL_W'(CTL_IDX))  regDataOut = DATA_W'({cfg, busyIn});
    if (regSel == SEL_W'(STAT_IDX)) regDataOut = DATA_W'({doneIn, busyIn});
  end

  assign busAddr    = strobe.rdPhase ? srcReg[ADDR_W-1:0] : dstReg[ADDR_W-1:0];
  assign busDataOut = byteLatch;

endmodule

// File: rtl/steal_copy_ctl.sv
`timescale 1ns/1ps
module steal_copy_ctl
  import steal_copy_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  xferCfg_t   cfg,
  input  logic       lastByte,
  input  logic       ctlWrite,
  input  logic       startBit,
  input  logic       statRead,
  input  logic       vda,
  input  logic       vpa,
  input  logic       busGrant,
  input  logic       dreq,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       done,
  output logic       busOe,
  output logic       busRwb,
  output logic       busDataOe,
  output logic       busReq,
  output logic       dack,
  output logic       irq
);

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} seqState_e;
  seqState_e state;

  logic abortNow, startNow, slotFree, portSide, sideReady, go, doneSet;

  always_comb begin
    busy      = (state != ST_IDLE);
    abortNow  = ctlWrite && busy && !startBit;
    startNow  = ctlWrite && !busy && startBit;
    slotFree  = cfg.burst ? busGrant : (!vda && !vpa);
    portSide  = ((state == ST_READ)  && (cfg.kind == KIND_PORT2MEM)) ||
                ((state == ST_WRITE) && (cfg.kind == KIND_MEM2PORT));
    sideReady = !portSide || !cfg.pace || dreq;
    go        = busy && slotFree && sideReady && !abortNow;

    strobe.rdPhase = (state == ST_READ);
    strobe.rdCycle = go && (state == ST_READ);
    strobe.wrCycle = go && (state == ST_WRITE);

    busOe     = go;
    busRwb    = !strobe.wrCycle;
    busDataOe = strobe.wrCycle;
    busReq    = busy && cfg.burst;
    dack      = go && portSide;
    doneSet   = abortNow || (strobe.wrCycle && lastByte);
    irq       = done && cfg.irqEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      if (abortNow)             state <= ST_IDLE;
      else if (startNow)        state <= ST_READ;
      else if (strobe.rdCycle)  state <= ST_WRITE;
      else if (strobe.wrCycle)  state <= lastByte ? ST_IDLE : ST_READ;

      if (doneSet)                    done <= 1'b1;
      else if (statRead || startNow)  done <= 1'b0;
    end
  end

endmodule

// File: rtl/steal_copy_dma.sv
`timescale 1ns/1ps
module steal_copy_dma
  import steal_copy_pkg::*;
#(
  parameter int REG_SEL_W = 4,
  parameter int ADDR_W    = 24,
  parameter int CNT_W     = 16,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic [REG_SEL_W-1:0] regSel,
  input  logic              cpuRwb,
  input  logic [DATA_W-1:0] cpuDataIn,
  output logic [DATA_W-1:0] regDataOut,
  input  logic              vda,
  input  logic              vpa,
  output logic              busReq,
  input  logic              busGrant,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busOe,
  output logic              busRwb,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  input  logic [DATA_W-1:0] busDataIn,
  input  logic              dreq,
  output logic              dack,
  output logic              irq
);

  seqStrobe_t strobe;
  xferCfg_t   cfg;
  logic       busy, done, lastByte, ctlWrite, statRead;

  steal_copy_dp #(
    .SEL_W (REG_SEL_W),
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .csN       (csN),
    .cpuRwb    (cpuRwb),
    .regSel    (regSel),
    .cpuDataIn (cpuDataIn),
    .regDataOut(regDataOut),
    .busyIn    (busy),
    .doneIn    (done),
    .strobe    (strobe),
    .busDataIn (busDataIn),
    .busAddr   (busAddr),
    .busDataOut(busDataOut),
    .cfg       (cfg),
    .lastByte  (lastByte),
    .ctlWrite  (ctlWrite),
    .statRead  (statRead)
  );

  steal_copy_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .cfg      (cfg),
    .lastByte (lastByte),
    .ctlWrite (ctlWrite),
    .startBit (cpuDataIn[0]),
    .statRead (statRead),
    .vda      (vda),
    .vpa      (vpa),
    .busGrant (busGrant),
    .dreq     (dreq),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done),
    .busOe    (busOe),
    .busRwb   (busRwb),
    .busDataOe(busDataOe),
    .busReq   (busReq),
    .dack     (dack),
    .irq      (irq)
  );

endmodule

// File: rtl/steal_copy_chk.sv
`timescale 1ns/1ps
module steal_copy_chk #(
  parameter int REG_SEL_W = 4,
  parameter int ADDR_W    = 24,
  parameter int CNT_W     = 16,
  parameter int DATA_W    = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 csN,
  input logic [REG_SEL_W-1:0] regSel,
  input logic                 cpuRwb,
  input logic                 vda,
  input logic                 vpa,
  input logic                 busReq,
  input logic                 busGrant,
  input logic                 busOe,
  input logic                 busRwb,
  input logic                 busDataOe,
  input logic                 dack,
  input logic                 irq
);

  localparam int ADDR_BYTES = (ADDR_W + DATA_W - 1) / DATA_W;
  localparam int CNT_BYTES  = (CNT_W + DATA_W - 1) / DATA_W;
  localparam int CTL_IDX    = 2 * ADDR_BYTES + CNT_BYTES;
  localparam int STAT_IDX   = CTL_IDX + 1;

  logic rdPending;
  logic ctlWr, statRd;

  assign ctlWr  = !csN && !cpuRwb && (regSel == REG_SEL_W'(CTL_IDX));
  assign statRd = !csN && cpuRwb && (regSel == REG_SEL_W'(STAT_IDX));

  always_ff @(posedge clk) begin
    if (!rstN)       rdPending <= 1'b0;
    else if (ctlWr)  rdPending <= 1'b0;
    else if (busOe)  rdPending <= busRwb;
  end

  AST_STEAL_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (busOe && !busReq) |-> (!vda && !vpa)); // R2

  AST_BURST_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    (busOe && busReq) |-> busGrant); // R7

  AST_DACK_IN_OWNED: assert property (@(posedge clk) disable iff (!rstN)
    dack |-> busOe); // R8

  AST_DATA_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    busDataOe |-> (busOe && !busRwb)); // R6

  AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rstN)
    (busOe && rdPending) |-> !busRwb); // R6

  AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (statRd && !(busOe && !busRwb)) |=> !irq); // R9

endmodule

bind steal_copy_dma steal_copy_chk #(
  .REG_SEL_W(REG_SEL_W),
  .ADDR_W   (ADDR_W),
  .CNT_W    (CNT_W),
  .DATA_W   (DATA_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .csN      (csN),
  .regSel   (regSel),
  .cpuRwb   (cpuRwb),
  .vda      (vda),
  .vpa      (vpa),
  .busReq   (busReq),
  .busGrant (busGrant),
  .busOe    (busOe),
  .busRwb   (busRwb),
  .busDataOe(busDataOe),
  .dack     (dack),
  .irq      (irq)
);

// File: tb/steal_copy_dma_bench.sv
`timescale 1ns/1ps
module steal_copy_dma_bench;

  localparam logic [23:0] PORT_ADDR = 24'h80_0000;
  localparam int CTL = 8;
  localparam int STAT = 9;

  logic clk = 1'b0, rstN = 1'b0;
  logic csN = 1'b1, cpuRwb = 1'b1;
  logic [3:0] regSel = '0;
  logic [7:0] cpuDataIn = '0, regDataOut, busDataOut, busDataIn;
  logic vda = 1'b1, vpa = 1'b1, dreq = 1'b1;
  logic busReq, busGrant, busOe, busRwb, busDataOe, dack, irq;
  logic [23:0] busAddr;

  int checks = 0, errors = 0;
  bit finished = 0;
  int stealMode = 0, dreqMode = 0, grantDelay = 0, grantWait = 0;
  bit grantAllow = 0, pacing = 0;
  logic [15:0] lfsr = 16'hACE1;
  int ownedCyc = 0, wrCyc = 0, gapCyc = 0, stealViol = 0, dackViol = 0;
  int dackCyc = 0, portCyc = 0, portWrN = 0;
  logic [7:0] portRdVal = 8'h00;
  logic [7:0] portLog [0:63];
  logic [7:0] mem [0:4095];

  steal_copy_dma u_steal_copy_dma (
    .clk(clk), .rstN(rstN), .csN(csN), .regSel(regSel), .cpuRwb(cpuRwb),
    .cpuDataIn(cpuDataIn), .regDataOut(regDataOut), .vda(vda), .vpa(vpa),
    .busReq(busReq), .busGrant(busGrant), .busAddr(busAddr), .busOe(busOe),
    .busRwb(busRwb), .busDataOut(busDataOut), .busDataOe(busDataOe),
    .busDataIn(busDataIn), .dreq(dreq), .dack(dack), .irq(irq)
  );

  always #2.5 clk = ~clk;

  assign busDataIn = (busAddr == PORT_ADDR) ? portRdVal : mem[busAddr[11:0]];
  assign busGrant  = busReq && grantAllow;

  // Processor status, device request and grant, all changed away from the active edge
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (stealMode == 0) begin vda = 1'b0; vpa = 1'b0; end
    else begin vda = lfsr[0]; vpa = lfsr[1] & lfsr[2]; end
    dreq = (dreqMode == 0) ? 1'b1 : (dreqMode == 1) ? lfsr[5] : 1'b0;
    if (busReq) grantWait++; else grantWait = 0;
    grantAllow = (grantWait > grantDelay);
  end

  // Memory, port and bus monitors
  always @(posedge clk) begin
    if (rstN) begin
      if (busOe && !busRwb) begin
        if (busAddr == PORT_ADDR) begin
          portLog[portWrN[5:0]] <= busDataOut;
          portWrN <= portWrN + 1;
        end else mem[busAddr[11:0]] <= busDataOut;
        wrCyc <= wrCyc + 1;
      end
      if (busOe && busRwb && busAddr == PORT_ADDR) portRdVal <= portRdVal + 8'd1;
      if (busOe) ownedCyc <= ownedCyc + 1;
      if (busReq && busGrant && !busOe) gapCyc <= gapCyc + 1;
      if (busOe && !busReq && (vda || vpa)) stealViol <= stealViol + 1;
      if (dack && pacing && !dreq) dackViol <= dackViol + 1;
      if (dack) dackCyc <= dackCyc + 1;
      if (busOe && busAddr == PORT_ADDR) portCyc <= portCyc + 1;
    end
  end

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finishRun();
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input int idx, input logic [7:0] v);
    @(negedge clk);
    csN = 1'b0; cpuRwb = 1'b0; regSel = idx[3:0]; cpuDataIn = v;
    @(negedge clk);
    csN = 1'b1; cpuRwb = 1'b1;
  endtask

  task automatic rdReg(input int idx, output logic [7:0] v);
    @(negedge clk);
    csN = 1'b0; cpuRwb = 1'b1; regSel = idx[3:0];
    #1 v = regDataOut;
    @(negedge clk);
    csN = 1'b1;
  endtask

  task automatic rdAddr(input int base, output logic [23:0] a);
    logic [7:0] b0, b1, b2;
    rdReg(base, b0); rdReg(base + 1, b1); rdReg(base + 2, b2);
    a = {b2, b1, b0};
  endtask

  task automatic rdCount(output logic [15:0] c);
    logic [7:0] b0, b1;
    rdReg(6, b0); rdReg(7, b1);
    c = {b1, b0};
  endtask

  task automatic setup(input logic [23:0] s, input logic [23:0] d, input logic [15:0] n);
    wrReg(0, s[7:0]); wrReg(1, s[15:8]); wrReg(2, s[23:16]);
    wrReg(3, d[7:0]); wrReg(4, d[15:8]); wrReg(5, d[23:16]);
    wrReg(6, n[7:0]); wrReg(7, n[15:8]);
  endtask

  task automatic clearCounters();
    ownedCyc = 0; wrCyc = 0; gapCyc = 0; dackViol = 0;
    dackCyc = 0; portCyc = 0; portWrN = 0;
  endtask

  task automatic start(input logic [1:0] kind, input bit burst, input bit ie, input bit pace);
    clearCounters();
    wrReg(CTL, {2'b00, pace, ie, burst, kind, 1'b1});
  endtask

  task automatic waitIdle(output logic [7:0] st);
    int polls;
    polls = 0;
    st = 8'h01;
    while (st[0] && polls < 30000) begin
      rdReg(STAT, st);
      polls++;
    end
    if (st[0]) chk("R3 transfer never finished", 1, 0);
  endtask

  initial begin
    logic [7:0] st, rv;
    logic [23:0] a;
    logic [15:0] c;
    int bad;
    for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7 + 3);
    repeat (4) @(posedge clk);
    rstN = 1'b1;

    // R1 reset state
    @(negedge clk); #1;
    chk("R1 busOe after reset", busOe, 0);
    chk("R1 busReq after reset", busReq, 0);
    chk("R1 dack/irq/dataOe after reset", {dack, irq, busDataOe}, 0);
    rdReg(STAT, rv); chk("R1 status after reset", rv, 0);
    rdReg(CTL, rv);  chk("R1 control after reset", rv, 0);
    rdAddr(0, a);    chk("R1 source after reset", a, 0);
    rdCount(c);      chk("R1 count after reset", c, 0);

    // R3 / R2 sweep: kinds 0 and 3, free and busy processor, several counts
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 2; s++)
        for (int j = 0; j < 4; j++) begin
          int n;
          logic [23:0] src, dst;
          n = (j == 0) ? 1 : (j == 1) ? 2 : (j == 2) ? 7 : 20;
          src = 24'h100 + 24'(j * 40);
          dst = 24'h600 + 24'((m * 8 + s * 4 + j) * 32);
          for (int i = 0; i < n; i++) mem[dst[11:0] + 12'(i)] = 8'h00;
          mem[dst[11:0] + 12'(n)] = 8'hEE;
          stealMode = s;
          stealViol = 0;
          setup(src, dst, 16'(n));
          start((m == 0) ? 2'd0 : 2'd3, 1'b0, 1'b0, 1'b0);
          waitIdle(st);
          bad = 0;
          for (int i = 0; i < n; i++)
            if (mem[dst[11:0] + 12'(i)] != mem[src[11:0] + 12'(i)]) bad++;
          chk("R3 copied bytes mismatching", bad, 0);
          chk("R3 byte past range", mem[dst[11:0] + 12'(n)], 8'hEE);
          chk("R9 done bit at end", st, 8'h02);
          rdAddr(0, a); chk("R3 source advanced", a, src + 24'(n));
          rdAddr(3, a); chk("R3 destination advanced", a, dst + 24'(n));
          rdCount(c);   chk("R3 count at end", c, 0);
          chk("R6 owned cycles equal 2N", ownedCyc, 2 * n);
          chk("R2 owned cycle with processor status high", stealViol, 0);
        end

    // R4 memory to port
    for (int j = 0; j < 2; j++) begin
      int n;
      n = (j == 0) ? 3 : 9;
      stealMode = 1;
      setup(24'h200, PORT_ADDR, 16'(n));
      start(2'd1, 1'b0, 1'b0, 1'b0);
      waitIdle(st);
      chk("R4 port write count", portWrN, n);
      bad = 0;
      for (int i = 0; i < n; i++) if (portLog[i] != mem[12'h200 + 12'(i)]) bad++;
      chk("R4 port bytes mismatching", bad, 0);
      rdAddr(3, a); chk("R4 destination fixed", a, PORT_ADDR);
      rdAddr(0, a); chk("R4 source advanced", a, 24'h200 + 24'(n));
      chk("R8 dack marks port cycles", dackCyc, portCyc);
    end

    // R5 / R8 port to memory, paced by a toggling request
    stealMode = 1; dreqMode = 1; pacing = 1;
    portRdVal = 8'h40;
    setup(PORT_ADDR, 24'h880, 16'd12);
    start(2'd2, 1'b0, 1'b0, 1'b1);
    waitIdle(st);
    bad = 0;
    for (int i = 0; i < 12; i++) if (mem[12'h880 + 12'(i)] != 8'(8'h40 + i)) bad++;
    chk("R5 port bytes stored", bad, 0);
    rdAddr(0, a); chk("R5 source fixed", a, PORT_ADDR);
    chk("R8 dack without request", dackViol, 0);
    chk("R8 dack count equals port cycles", dackCyc, 12);

    // R8 request held low stalls the port side
    dreqMode = 2;
    setup(PORT_ADDR, 24'h8A0, 16'd4);
    start(2'd2, 1'b0, 1'b0, 1'b1);
    repeat (30) @(negedge clk);
    #1 chk("R8 no cycle while request low", ownedCyc, 0);
    dreqMode = 0;
    waitIdle(st);
    chk("R8 completes after request", wrCyc, 4);
    pacing = 0;

    // R5 fill: seed then fixed-source copy
    mem[12'h900] = 8'h5A;
    for (int i = 1; i <= 16; i++) mem[12'h900 + 12'(i)] = 8'h00;
    setup(24'h900, 24'h901, 16'd15);
    start(2'd2, 1'b0, 1'b0, 1'b0);
    waitIdle(st);
    bad = 0;
    for (int i = 0; i < 16; i++) if (mem[12'h900 + 12'(i)] != 8'h5A) bad++;
    chk("R5 fill bytes", bad, 0);
    chk("R5 fill stops at range end", mem[12'h910], 8'h00);

    // R7 / R6 burst with delayed grant
    stealMode = 1; grantDelay = 6;
    setup(24'h140, 24'hC00, 16'd10);
    start(2'd0, 1'b1, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    #1 chk("R7 request raised in burst", busReq, 1);
    chk("R7 no ownership before grant", ownedCyc, 0);
    waitIdle(st);
    chk("R6 burst owned cycles", ownedCyc, 20);
    chk("R6 burst back to back", gapCyc, 0);
    bad = 0;
    for (int i = 0; i < 10; i++) if (mem[12'hC00 + 12'(i)] != mem[12'h140 + 12'(i)]) bad++;
    chk("R3 burst copy bytes", bad, 0);
    @(negedge clk); #1 chk("R7 request dropped when idle", busReq, 0);
    grantDelay = 0;

    // R9 interrupt enabled
    stealMode = 0;
    setup(24'h100, 24'hD00, 16'd4);
    start(2'd0, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 200 && !irq; i++) @(negedge clk);
    #1 chk("R9 irq at completion", irq, 1);
    rdReg(STAT, rv); chk("R9 status shows done", rv, 8'h02);
    #1 chk("R9 irq cleared by status read", irq, 0);
    rdReg(STAT, rv); chk("R9 done cleared by read", rv, 8'h00);

    // R9 interrupt disabled
    setup(24'h100, 24'hD10, 16'd3);
    start(2'd0, 1'b0, 1'b0, 1'b0);
    repeat (40) @(negedge clk);
    #1 chk("R9 irq masked", irq, 0);
    rdReg(STAT, rv); chk("R9 done without irq", rv, 8'h02);

    // R11 writes while busy are ignored
    stealMode = 1;
    setup(24'h300, 24'hA00, 16'd20);
    start(2'd0, 1'b0, 1'b0, 1'b0);
    wrReg(0, 8'hAA);
    wrReg(6, 8'h01);
    wrReg(CTL, 8'h05);
    waitIdle(st);
    bad = 0;
    for (int i = 0; i < 20; i++) if (mem[12'hA00 + 12'(i)] != mem[12'h300 + 12'(i)]) bad++;
    chk("R11 copy unaffected", bad, 0);
    rdAddr(0, a); chk("R11 source write ignored", a, 24'h300 + 24'd20);
    rdReg(CTL, rv); chk("R11 control write ignored", rv, 8'h00);

    // R10 / R12 count zero in burst, then abort
    stealMode = 0;
    setup(24'h000, 24'hB00, 16'd0);
    start(2'd0, 1'b1, 1'b0, 1'b0);
    repeat (41) @(negedge clk);
    wrReg(CTL, 8'h00);
    chk("R10 bytes moved before abort", (wrCyc > 0) ? 1 : 0, 1);
    rdCount(c); chk("R10 count from 65536", c, 16'(32'h10000 - wrCyc));
    rdAddr(3, a); chk("R12 destination at abort", a, 24'hB00 + 24'(wrCyc));
    rdReg(STAT, rv); chk("R12 abort sets done", rv, 8'h02);
    begin
      int held;
      held = ownedCyc;
      repeat (10) @(negedge clk);
      #1 chk("R12 no cycles after abort", ownedCyc, held);
    end
    chk("R7 request dropped after abort", busReq, 0);
    chk("R2 steal rule overall", stealViol, 0);

    finishRun();
  end

endmodule